// File: doc/BRIEF.md
# Self-Starting Bidirectional One-Hot Ring Counter

This block is a parameterised ring of `STAGES` flip-flops that carries one active bit. On each enabled clock the active bit moves one stage toward the higher index (up) or toward the lower index (down), wrapping at the ends. So the ring walks through exactly `STAGES` distinct one-hot codes. Each output bit can drive one step of a cyclic control sequence directly, with no decoder.

The ring needs no preset to start. A per-direction feedback gate puts a 1 into the entry stage whenever every stage except the exit stage is empty. This lets the ring start from all zeros, and it drains any extra ones within `STAGES` enabled clocks. A combinational flag reports any state whose population count is not exactly one. Because legal codes are at least two bit flips apart, every single-bit upset is flagged.

A synchronous reset still loads a known starting code. The enable input freezes the ring.

Top module: `ring_walker`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes stage 0 set and all other stages clear (vector value 1). This holds regardless of `en` and `dir_down`.
- R2: With `rst` low and `en` low, the state is unchanged across the clock edge, whether or not it is a legal code.
- R3: With `en` high and `dir_down` = 0 (up), stage i takes the old value of stage i-1 for i >= 1. From a legal code the 1 in stage `STAGES-1` wraps to stage 0. With 4 stages and bit i = stage i, the vector runs 0001, 0010, 0100, 1000, 0001.
- R4: With `en` high and `dir_down` = 1 (down), stage i takes the old value of stage i+1 for i <= `STAGES-2`. From a legal code the 1 in stage 0 wraps to stage `STAGES-1`.
- R5: When counting up, stage 0 is loaded with 1 exactly when stages 0 to `STAGES-2` all hold 0, and with 0 otherwise. For example, all-zeros steps to vector value 1.
- R6: When counting down, stage `STAGES-1` is loaded with 1 exactly when stages 1 to `STAGES-1` all hold 0, and with 0 otherwise. For example, all-zeros steps to only the top stage set.
- R7: `bad_code` is high, combinationally in the same cycle, exactly when the number of set stages is not one. This means all-zeros, every multi-hot state and every single-bit flip of a legal code raise it.
- R8: From any state, after at most `STAGES` enabled clocks in one fixed direction, the state is a legal one-hot code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, loads stage 0 |
| en | input | 1 | Step enable; low freezes the ring |
| dir_down | input | 1 | 0 = shift up (toward higher index), 1 = shift down |
| ring_q | output | STAGES | Ring state, bit i is stage i |
| bad_code | output | 1 | High when `ring_q` is not exactly one-hot |

## Verification
The bound checker watches several rules on every cycle:
- the reset load, the freeze while disabled and the shift-and-wrap in both directions from legal codes;
- the entry-stage gate in both directions;
- agreement of the error flag with a population count of the state;
- a counter-based bound that no illegal state survives `STAGES` enabled steps in one direction.

Reaching illegal states at all needs the bench's scenarios. The bench plants all-zeros, every single-bit corruption of every legal code and several multi-hot patterns. It then follows each recovery cycle by cycle against a reference model in both directions.

// File: rtl/ring_pkg.sv
package ring_pkg;

   // Shift direction as seen on the dir_down pin
   typedef enum logic {
      DIR_UP   = 1'b0,
      DIR_DOWN = 1'b1
   } ring_dir_e;

   // Implementations of the illegal-code detector
   localparam int CHK_SCAN     = 0;  // running seen/duplicate chain
   localparam int CHK_POPCOUNT = 1;  // adder-based population count

endpackage

// File: rtl/ring_seed_gate.sv
// Entry-stage feedback for both directions: a stage at the ring entry is
// loaded with 1 only when every stage except the exit stage is empty.
module ring_seed_gate #(
   parameter int STAGES = 4
) (
   input  logic [STAGES-1:0] state,
   output logic              seed_up,
   output logic              seed_dn
);

   // up: exit stage is STAGES-1, watch stages 0..STAGES-2
   assign seed_up = ~|state[STAGES-2:0];
   // down: exit stage is 0, watch stages 1..STAGES-1
   assign seed_dn = ~|state[STAGES-1:1];

endmodule

// File: rtl/ring_step_mux.sv
// Per-stage neighbour select.
module ring_step_mux
   import ring_pkg::*;
(
   input  logic from_lo,
   input  logic from_hi,
   input  logic go_down,
   output logic nxt
);

   ring_dir_e dir;
   assign dir = ring_dir_e'(go_down);
   assign nxt = (dir == DIR_DOWN) ? from_hi : from_lo;

endmodule

// File: rtl/ring_code_check.sv
// Flags any code whose population count differs from one.
module ring_code_check
   import ring_pkg::*;
#(
   parameter int STAGES = 4,
   parameter int STYLE  = CHK_SCAN
) (
   input  logic [STAGES-1:0] code,
   output logic              bad
);

   if (STYLE == CHK_SCAN) begin : g_scan
      logic seen;
      logic dup;
      always_comb begin
         seen = 1'b0;
         dup  = 1'b0;
         for (int i = 0; i < STAGES; i++) begin
            dup  = dup | (seen & code[i]);
            seen = seen | code[i];
         end
         bad = dup | ~seen;
      end
   end else begin : g_popcount
      localparam int CW = $clog2(STAGES + 1);
      logic [CW-1:0] ones;
      always_comb begin
         ones = '0;
         for (int i = 0; i < STAGES; i++) begin
            ones = ones + CW'(code[i]);
         end
         bad = (ones != CW'(1));
      end
   end

endmodule

// File: rtl/ring_walker.sv
module ring_walker
   import ring_pkg::*;
#(
   parameter int STAGES      = 4,
   parameter int CHECK_STYLE = CHK_SCAN
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic              dir_down,
   output logic [STAGES-1:0] ring_q,
   output logic              bad_code
);

   localparam logic [STAGES-1:0] START_CODE = STAGES'(1);

   if (STAGES < 2) begin : g_bad_stages
      $error("ring_walker: STAGES must be at least 2");
   end
   if (CHECK_STYLE != CHK_SCAN && CHECK_STYLE != CHK_POPCOUNT) begin : g_bad_style
      $error("ring_walker: CHECK_STYLE selects no detector");
   end

   logic [STAGES-1:0] state_q;
   logic [STAGES-1:0] state_nxt;
   logic              seed_up;
   logic              seed_dn;

   ring_seed_gate #(.STAGES(STAGES)) u_seed (
      .state   (state_q),
      .seed_up (seed_up),
      .seed_dn (seed_dn)
   );

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic from_lo;
      logic from_hi;
      if (i == 0) begin : g_lo_entry
         assign from_lo = seed_up;
      end else begin : g_lo_link
         assign from_lo = state_q[i-1];
      end
      if (i == STAGES - 1) begin : g_hi_entry
         assign from_hi = seed_dn;
      end else begin : g_hi_link
         assign from_hi = state_q[i+1];
      end
      ring_step_mux u_mux (
         .from_lo (from_lo),
         .from_hi (from_hi),
         .go_down (dir_down),
         .nxt     (state_nxt[i])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= START_CODE;
      end else if (en) begin
         state_q <= state_nxt;
      end
   end

   ring_code_check #(.STAGES(STAGES), .STYLE(CHECK_STYLE)) u_code (
      .code (state_q),
      .bad  (bad_code)
   );

   assign ring_q = state_q;

endmodule

// File: rtl/ring_walker_chk.sv
module ring_walker_chk #(
   parameter int STAGES = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              en,
   input logic              dir_down,
   input logic [STAGES-1:0] ring_q,
   input logic              bad_code
);

   localparam logic [STAGES-1:0] START_CODE = STAGES'(1);
   localparam int               CW         = $clog2(STAGES + 2);

   // Set by a bench while it plants an arbitrary state between edges.
   logic pause_chk = 1'b0;

   logic rst_d;
   always_ff @(posedge clk) begin
      rst_d <= rst;
      if (rst_d && !pause_chk) begin
         // R1
         r1_reset_load_chk : assert (ring_q == START_CODE)
            else $error("reset did not load the start code");
      end
   end

   // R2
   hold_when_idle_chk : assert property (@(posedge clk) disable iff (rst || pause_chk)
      !en |=> ring_q == $past(ring_q));

   // R3
   up_shift_chk : assert property (@(posedge clk) disable iff (rst || pause_chk)
      (en && !dir_down && !bad_code) |=>
      ring_q == {$past(ring_q[STAGES-2:0]), $past(ring_q[STAGES-1])});

   // R4
   down_shift_chk : assert property (@(posedge clk) disable iff (rst || pause_chk)
      (en && dir_down && !bad_code) |=>
      ring_q == {$past(ring_q[0]), $past(ring_q[STAGES-1:1])});

   // R5
   up_seed_chk : assert property (@(posedge clk) disable iff (rst || pause_chk)
      (en && !dir_down) |=> ring_q[0] == ($past(ring_q[STAGES-2:0]) == '0));

   // R6
   down_seed_chk : assert property (@(posedge clk) disable iff (rst || pause_chk)
      (en && dir_down) |=> ring_q[STAGES-1] == ($past(ring_q[STAGES-1:1]) == '0));

   // R7
   flag_matches_count_chk : assert property (@(posedge clk) disable iff (rst)
      bad_code == ($countones(ring_q) != 1));

   // Enabled steps taken in one direction while the state stayed illegal
   logic [CW-1:0] stuck_cnt;
   logic          last_down;
   always_ff @(posedge clk) begin
      if (rst) begin
         stuck_cnt <= '0;
         last_down <= 1'b0;
      end else begin
         if (en) last_down <= dir_down;
         if (!bad_code) stuck_cnt <= '0;
         else if (en) stuck_cnt <= (dir_down == last_down) ? stuck_cnt + CW'(1) : CW'(1);
      end
   end

   // R8
   recovery_bound_chk : assert property (@(posedge clk) disable iff (rst)
      bad_code |-> stuck_cnt < CW'(STAGES));

endmodule

bind ring_walker ring_walker_chk #(.STAGES(STAGES)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .en       (en),
   .dir_down (dir_down),
   .ring_q   (ring_q),
   .bad_code (bad_code)
);

// File: tb/test_ring_walker.sv
module test_ring_walker;

   localparam int N = 4;
   localparam logic [N-1:0] START = N'(1);

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         en = 1'b0;
   logic         dir_down = 1'b0;
   logic [N-1:0] ring_q;
   logic         bad_code;

   ring_walker #(.STAGES(N)) i_ring_walker (
      .clk      (clk),
      .rst      (rst),
      .en       (en),
      .dir_down (dir_down),
      .ring_q   (ring_q),
      .bad_code (bad_code)
   );

   always #5 clk = ~clk;

   typedef struct {
      logic [N-1:0] q;
      logic         bad;
      string        tag;
   } exp_t;

   exp_t         sb[$];
   int           checks = 0;
   int           fails = 0;
   logic [N-1:0] model_q = START;
   bit           done = 1'b0;

   function automatic logic illegal(logic [N-1:0] v);
      int c = 0;
      for (int i = 0; i < N; i++) c += int'(v[i]);
      return c != 1;
   endfunction

   // Reference step from the requirements (R3..R6)
   function automatic logic [N-1:0] model_next(logic [N-1:0] v, logic down);
      if (!down) return {v[N-2:0], (v[N-2:0] == '0)};
      else       return {(v[N-1:1] == '0), v[N-1:1]};
   endfunction

   task automatic check(string tag, logic [N-1:0] aq, logic [N-1:0] eq,
                        logic ab, logic eb);
      checks++;
      if (aq !== eq || ab !== eb) begin
         fails++;
         $display("FAIL %s: ring_q=%b bad_code=%b expected ring_q=%b bad_code=%b",
                  tag, aq, ab, eq, eb);
      end
   endtask

   // Driver: applies inputs and queues the state expected after the next edge
   task automatic drive(logic r, logic e, logic d, string tag);
      @(negedge clk);
      i_ring_walker.u_chk.pause_chk = 1'b0;
      rst = r; en = e; dir_down = d;
      if (r) model_q = START;
      else if (e) model_q = model_next(model_q, d);
      sb.push_back('{model_q, illegal(model_q), tag});
   endtask

   // Plants a state between edges, checks the flag at once, then holds it
   task automatic inject(logic [N-1:0] pat, string tag);
      @(negedge clk);
      i_ring_walker.u_chk.pause_chk = 1'b1;
      rst = 1'b0; en = 1'b0;
      force i_ring_walker.state_q = pat;
      #1;
      release i_ring_walker.state_q;
      check(tag, ring_q, pat, bad_code, illegal(pat));
      model_q = pat;
      sb.push_back('{model_q, illegal(model_q), "R2 hold of planted state"});
   endtask

   task automatic settle();
      wait (sb.size() == 0);
      #1;
   endtask

   // Monitor: compares each queued expectation after its edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, ring_q, e.q, bad_code, e.bad);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [N-1:0] pats[3];
      pats[0] = '1;
      for (int i = 0; i < N; i++) pats[1][i] = (i % 2 == 0);
      pats[2] = START | (N'(1) << (N - 1));

      drive(1, 1, 0, "R1 reset load with enable high");
      drive(1, 0, 1, "R1 reset load");
      for (int k = 0; k < 2 * N; k++) drive(0, 1, 0, "R3 up shift and wrap");
      for (int k = 0; k < 3; k++) drive(0, 0, 0, "R2 hold while disabled");
      for (int k = 0; k < 2 * N; k++) drive(0, 1, 1, "R4 down shift and wrap");
      drive(0, 1, 0, "R3 up after down");
      drive(1, 1, 1, "R1 reset wins over enable");
      for (int k = 0; k < 2; k++) drive(0, 0, 1, "R2 hold after reset");

      inject('0, "R7 all-zero flagged");
      drive(0, 1, 0, "R5 all-zero self-start up");
      drive(0, 1, 0, "R3 up from self-started code");
      inject('0, "R7 all-zero flagged");
      drive(0, 1, 1, "R6 all-zero self-start down");
      drive(0, 1, 1, "R4 down from self-started code");
      settle();

      for (int v = 0; v < N; v++) begin
         for (int b = 0; b < N; b++) begin
            inject((N'(1) << v) ^ (N'(1) << b), "R7 single-bit upset flagged");
         end
      end

      for (int p = 0; p < 3; p++) begin
         for (int d = 0; d < 2; d++) begin
            inject(pats[p], "R7 multi-hot flagged");
            for (int k = 0; k < N; k++)
               drive(0, 1, d[0], d[0] ? "R6 down recovery step" : "R5 up recovery step");
            settle();
            checks++;
            if (bad_code !== 1'b0) begin
               fails++;
               $display("FAIL R8: bad_code=%b after %0d steps, expected 0", bad_code, N);
            end
         end
      end

      drive(0, 1, 0, "R3 up after recovery");
      settle();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule